// File: doc/BRIEF.md
# Daisy-Chain Serial Converter Frame Host

This block is the host side of a serial link to a chain of identical converters that share one active-low chip-select and one serial clock. The host data output feeds the first converter, each converter's output feeds the next, and the output of the last converter returns to the host input. One frame loads a new command word into every converter and collects one result word from every converter. All converters sample their inputs when chip-select returns high.

A frame starts with a one-cycle `start` strobe while the block is idle. The block pulls chip-select low and drives exactly `WORD_W × N_DEV` serial clock pulses, each half period `HALF_DIV` system clocks long (mode 0: clock idles low, data changes on the falling edge, data is captured on the rising edge). It sends the flat command vector most significant bit first, so the word for the far end of the chain leaves first and each word has reached its own converter when chip-select rises. The words read back from the end of the chain are placed into the result vector in chain order. Chip-select then goes high together with a one-cycle `done` pulse, and it stays high for at least `conv_cycles` clocks of conversion time before another frame can begin. Every converter in the chain should receive the same configuration. The block only controls frame timing and word order.

Top module: `dchain_spi_host`

## Requirements
- R1: After synchronous reset, `cs_n` is 1, `sclk` is 0, `done` is 0 and `rsp_words` is all zeros.
- R2: While `cs_n` is low, `sclk` makes exactly `WORD_W*N_DEV` rising edges. `sclk` is low whenever `cs_n` is high.
- R3: Each `sclk` level lasts `HALF_DIV` system clocks. `cs_n` stays low for exactly `2*HALF_DIV*WORD_W*N_DEV` clocks per frame.
- R4: `mosi` sends `cmd_words` most significant bit first. The slice `[k*WORD_W +: WORD_W]` is the command for device k (device 0 is next to the host output), so the word for device `N_DEV-1` leaves first. When `cs_n` rises, device k holds its own command.
- R5: The bits captured on `miso` at rising `sclk` edges are placed so that `rsp_words[k*WORD_W +: WORD_W]` is the word device k held at frame start. The first word to arrive belongs to device `N_DEV-1`.
- R6: `done` is high for exactly one cycle, in the first cycle in which `cs_n` is high again. `rsp_words` changes only in that cycle.
- R7: Between the end of one frame and the fall of `cs_n` for the next, `cs_n` stays high for at least `conv_cycles` clocks.
- R8: `start` is ignored while a frame or its conversion gap is in progress. `cmd_words` is sampled only when a frame is accepted, so later changes do not affect the words delivered.
- R9: `mosi` changes only together with a falling `sclk` or while `cs_n` is high. It is stable while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame request strobe, accepted only when idle |
| cmd_words | input | N_DEV*WORD_W | Command for device k at bits [k*WORD_W +: WORD_W] |
| conv_cycles | input | CONV_W | Minimum chip-select high time after a frame, in clocks |
| rsp_words | output | N_DEV*WORD_W | Result from device k at bits [k*WORD_W +: WORD_W] |
| done | output | 1 | One-cycle pulse when results are valid |
| cs_n | output | 1 | Shared active-low chip-select |
| sclk | output | 1 | Shared serial clock |
| mosi | output | 1 | Serial data to the first device |
| miso | input | 1 | Serial data from the last device |

## Verification
The hardest case to reach is a `start` that arrives during the conversion gap, just after chip-select has risen. In that window the block looks almost idle, but it must still refuse the request and keep chip-select high for the full programmed time. The bench holds `start` high for a whole frame and beyond, with a long `conv_cycles`, and counts the high time before the next frame begins. A second test changes `cmd_words` and pulses `start` in the middle of a frame, then checks that the devices hold the words that were sampled when the frame began.

// File: rtl/dchain_pkg.sv
// Package: shared types for the daisy-chain frame host.
// Assumes: nothing; holds only the frame state encoding.
package dchain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } frame_st_t;
endpackage

// File: rtl/dchain_sclk_gen.sv
// Module: serial clock generator.
// Holds sclk low while run is low. While run is high it toggles sclk every
// HALF_DIV clocks and flags the cycle before each rising and falling edge.
// Assumes HALF_DIV >= 1.
module dchain_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             tick;

    // Half-period reached while running.
    assign tick      = run && (div_cnt == DIV_LAST);
    assign rise_tick = tick && !sclk;
    assign fall_tick = tick && sclk;

    // Divider counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (tick) begin
            div_cnt <= '0;
            sclk    <= ~sclk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dchain_shift_path.sv
// Module: transmit and receive shift registers for one whole frame.
// Loads the flat command vector and shifts it out MSB first on fall ticks.
// Shifts miso in as the LSB on rise ticks. Assumes miso is synchronous to clk,
// which holds because sclk is derived from clk.
module dchain_shift_path #(
    parameter int TOTAL_BITS = 96
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [TOTAL_BITS-1:0] load_data,
    input  logic                  shift_tick,
    input  logic                  capture_tick,
    input  logic                  miso,
    output logic                  mosi,
    output logic [TOTAL_BITS-1:0] rx_data
);
    logic [TOTAL_BITS-1:0] tx_sr;
    logic [TOTAL_BITS-1:0] rx_sr;

    assign mosi    = tx_sr[TOTAL_BITS-1];
    assign rx_data = rx_sr;

    // Outgoing command bits, far-end device first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_data;
        end else if (shift_tick) begin
            tx_sr <= {tx_sr[TOTAL_BITS-2:0], 1'b0};
        end
    end

    // Incoming result bits from the end of the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (capture_tick) begin
            rx_sr <= {rx_sr[TOTAL_BITS-2:0], miso};
        end
    end
endmodule

// File: rtl/dchain_frame_ctrl.sv
// Module: frame sequencer.
// Accepts start only when idle, keeps chip-select low for TOTAL_BITS rising
// edges, ends the frame on the following falling edge, then holds chip-select
// high for conv_cycles+1 clocks before returning to idle.
module dchain_frame_ctrl
    import dchain_pkg::*;
#(
    parameter int TOTAL_BITS = 96,
    parameter int CONV_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CONV_W-1:0] conv_cycles,
    input  logic              rise_tick,
    input  logic              fall_tick,
    output logic              cs_n,
    output logic              run,
    output logic              load,
    output logic              frame_end
);
    localparam int CNT_W = $clog2(TOTAL_BITS + 1);
    localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(TOTAL_BITS);

    frame_st_t         st;
    logic [CNT_W-1:0]  rise_cnt;
    logic [CONV_W-1:0] gap_cnt;

    assign run       = (st == ST_SHIFT);
    assign load      = (st == ST_IDLE) && start;
    assign frame_end = run && fall_tick && (rise_cnt == EDGE_LAST);

    // Frame state, edge count, conversion gap and chip-select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cs_n     <= 1'b1;
            rise_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st       <= ST_SHIFT;
                        cs_n     <= 1'b0;
                        rise_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (rise_tick) begin
                        rise_cnt <= rise_cnt + 1'b1;
                    end
                    if (frame_end) begin
                        st      <= ST_GAP;
                        cs_n    <= 1'b1;
                        gap_cnt <= conv_cycles;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dchain_spi_host.sv
// Module: daisy-chain frame host top.
// Joins the sequencer, the clock generator and the shift path. Publishes the
// received frame and a done pulse when chip-select rises. Assumes N_DEV >= 1,
// WORD_W >= 2, and that every device is configured identically.
module dchain_spi_host #(
    parameter int N_DEV    = 3,
    parameter int WORD_W   = 32,
    parameter int HALF_DIV = 2,
    parameter int CONV_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_DEV*WORD_W-1:0] cmd_words,
    input  logic [CONV_W-1:0]       conv_cycles,
    output logic [N_DEV*WORD_W-1:0] rsp_words,
    output logic                    done,
    output logic                    cs_n,
    output logic                    sclk,
    output logic                    mosi,
    input  logic                    miso
);
    localparam int TOTAL_BITS = N_DEV * WORD_W;

    logic                  run;
    logic                  load;
    logic                  frame_end;
    logic                  rise_tick;
    logic                  fall_tick;
    logic [TOTAL_BITS-1:0] rx_data;

    dchain_frame_ctrl #(
        .TOTAL_BITS(TOTAL_BITS),
        .CONV_W    (CONV_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .conv_cycles(conv_cycles),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .cs_n       (cs_n),
        .run        (run),
        .load       (load),
        .frame_end  (frame_end)
    );

    dchain_sclk_gen #(
        .HALF_DIV(HALF_DIV)
    ) sclk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (sclk),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    dchain_shift_path #(
        .TOTAL_BITS(TOTAL_BITS)
    ) path_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_data   (cmd_words),
        .shift_tick  (fall_tick),
        .capture_tick(rise_tick),
        .miso        (miso),
        .mosi        (mosi),
        .rx_data     (rx_data)
    );

    // Publish results and pulse done as chip-select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_words <= '0;
            done      <= 1'b0;
        end else begin
            done <= frame_end;
            if (frame_end) begin
                rsp_words <= rx_data;
            end
        end
    end
endmodule

// File: rtl/dchain_spi_host_chk.sv
// Module: protocol checker bound to the frame host.
// Counts sclk rising edges per frame and chip-select high time with its own
// counters, and checks the port rules over time.
module dchain_spi_host_chk #(
    parameter int TOTAL_BITS = 96,
    parameter int CONV_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  sclk,
    input logic                  mosi,
    input logic                  done,
    input logic [CONV_W-1:0]     conv_cycles,
    input logic [TOTAL_BITS-1:0] rsp_words
);
    localparam int CNT_W = $clog2(TOTAL_BITS + 2);
    localparam logic [CNT_W-1:0] EDGE_EXP = CNT_W'(TOTAL_BITS);

    logic             sclk_q;
    logic [CNT_W-1:0] edge_seen;
    logic [CONV_W:0]  hi_cnt;

    // Rising sclk edges seen while chip-select is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            edge_seen <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n) begin
                edge_seen <= '0;
            end else if (sclk && !sclk_q) begin
                edge_seen <= edge_seen + 1'b1;
            end
        end
    end

    // Chip-select high time, saturating, starting full after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '1;
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != '1) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (edge_seen == EDGE_EXP));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rsp_words));

    p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= {1'b0, conv_cycles}));

    p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

bind dchain_spi_host dchain_spi_host_chk #(
    .TOTAL_BITS(N_DEV * WORD_W),
    .CONV_W    (CONV_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .mosi       (mosi),
    .done       (done),
    .conv_cycles(conv_cycles),
    .rsp_words  (rsp_words)
);

// File: tb/dchain_spi_host_tb_top.sv
// Directed bench: models the converter chain as one long shift register
// clocked by sclk, and checks every frame at the ports.
module dchain_spi_host_tb_top;
    localparam int N_DEV    = 3;
    localparam int WORD_W   = 32;
    localparam int HALF_DIV = 2;
    localparam int CONV_W   = 8;
    localparam int TOTAL    = N_DEV * WORD_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [TOTAL-1:0] cmd_words = '0;
    logic [CONV_W-1:0] conv_cycles = 8'd5;
    logic [TOTAL-1:0] rsp_words;
    logic             done;
    logic             cs_n;
    logic             sclk;
    logic             mosi;
    logic             miso;

    int tests_run = 0;
    int tests_failed = 0;

    always #2 clk = ~clk;

    dchain_spi_host #(
        .N_DEV(N_DEV), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .CONV_W(CONV_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_words(cmd_words),
        .conv_cycles(conv_cycles), .rsp_words(rsp_words), .done(done),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Chain model: device k occupies bits [k*WORD_W +: WORD_W].
    logic [TOTAL-1:0] chain = '0;
    logic [TOTAL-1:0] preload_val = '0;
    logic             preload_req = 1'b0;
    logic [TOTAL-1:0] dev_latched = '0;
    int               rise_total = 0;

    assign miso = chain[TOTAL-1];

    always @(posedge sclk or posedge preload_req) begin
        if (preload_req) chain <= preload_val;
        else if (!cs_n) chain <= {chain[TOTAL-2:0], mosi};
    end

    always @(posedge sclk) rise_total <= rise_total + 1;

    always @(posedge cs_n) dev_latched <= chain;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [TOTAL-1:0] v);
        preload_val = v;
        preload_req = 1'b1;
        #1;
        preload_req = 1'b0;
    endtask

    // One full frame with checks of timing, ordering and results.
    task automatic run_frame(input logic [TOTAL-1:0] cmd, input logic [TOTAL-1:0] devdata);
        int low_cyc = 0;
        int hi_cyc = 0;
        int wait_cyc = 0;
        int r0;
        bit rsp_moved = 0;
        logic [TOTAL-1:0] rsp_prev;
        @(negedge clk);
        preload(devdata);
        cmd_words = cmd;
        r0 = rise_total;
        rsp_prev = rsp_words;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && wait_cyc < 5000) begin
            if (!cs_n) low_cyc++;
            if (sclk) hi_cyc++;
            if (rsp_words !== rsp_prev) rsp_moved = 1;
            @(negedge clk);
            wait_cyc++;
        end
        check(done === 1'b1, "R6", "done seen", {{(TOTAL-1){1'b0}}, done}, 1);
        check(cs_n === 1'b1, "R6", "cs_n high at done", {{(TOTAL-1){1'b0}}, cs_n}, 1);
        check(!rsp_moved, "R6", "rsp stable during frame", rsp_words, rsp_prev);
        check(rise_total - r0 == TOTAL, "R2", "sclk rises", TOTAL'(rise_total - r0), TOTAL'(TOTAL));
        check(low_cyc == 2 * HALF_DIV * TOTAL, "R3", "cs_n low cycles", TOTAL'(low_cyc), TOTAL'(2 * HALF_DIV * TOTAL));
        check(hi_cyc == HALF_DIV * TOTAL, "R3", "sclk high cycles", TOTAL'(hi_cyc), TOTAL'(HALF_DIV * TOTAL));
        check(dev_latched === cmd, "R4", "device command words", dev_latched, cmd);
        check(rsp_words === devdata, "R5", "result words", rsp_words, devdata);
        @(negedge clk);
        check(done === 1'b0, "R6", "done one cycle", {{(TOTAL-1){1'b0}}, done}, 0);
        repeat (int'(conv_cycles) + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b0 && done === 1'b0, "R1", "reset pins",
              {{(TOTAL-3){1'b0}}, cs_n, sclk, done}, 3'b100);
        check(rsp_words === '0, "R1", "reset rsp", rsp_words, '0);
    endtask

    task automatic t_patterns();
        logic [TOTAL-1:0] c;
        logic [TOTAL-1:0] d;
        for (int k = 0; k < N_DEV; k++) begin
            c[k*WORD_W +: WORD_W] = 32'hC0DE_0000 + WORD_W'(k);
            d[k*WORD_W +: WORD_W] = 32'hA500_0000 + WORD_W'(k * 7);
        end
        run_frame(c, d);
        run_frame({TOTAL{1'b1}}, '0);
        run_frame('0, {TOTAL{1'b1}});
        run_frame({(TOTAL/2){2'b10}}, {(TOTAL/2){2'b01}});
    endtask

    // Start pulsed and commands changed mid-frame must have no effect (R8).
    task automatic t_midframe();
        logic [TOTAL-1:0] c = {(TOTAL/4){4'h9}};
        logic [TOTAL-1:0] d = {(TOTAL/4){4'h3}};
        int falls = 0;
        logic cs_prev;
        @(negedge clk);
        preload(d);
        cmd_words = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        cmd_words = ~c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cs_prev = cs_n;
        repeat (4 * TOTAL * HALF_DIV) begin
            @(negedge clk);
            if (cs_prev && !cs_n) falls++;
            cs_prev = cs_n;
        end
        check(dev_latched === c, "R8", "commands sampled at start", dev_latched, c);
        check(falls == 0, "R8", "no extra frame", TOTAL'(falls), 0);
    endtask

    // Start held high across the gap: high time must cover conv_cycles (R7).
    task automatic t_gap();
        int hi = 0;
        int w = 0;
        conv_cycles = 8'd40;
        repeat (60) @(negedge clk);
        cmd_words = {(TOTAL/8){8'h5A}};
        start = 1'b1;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        while (cs_n && w < 10000) begin hi++; @(negedge clk); w++; end
        check(!cs_n && hi >= 40, "R7", "cs_n high time", TOTAL'(hi), TOTAL'(40));
        check(hi < 60, "R7", "gap bounded", TOTAL'(hi), TOTAL'(60));
        start = 1'b0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        check(done === 1'b1, "R8", "second frame completes", {{(TOTAL-1){1'b0}}, done}, 1);
        repeat (60) @(negedge clk);
        conv_cycles = 8'd5;
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_midframe();
        t_gap();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule